// File: doc/BRIEF.md
# Reconfigurable Bypass Mesh Router

The block connects a rectangular grid of single-bit processing cells. Every cell puts one broadcast bit on the block each cycle, and the block returns to every cell the bits that its neighbours present. A register holds one membership flag per cell. In full-resolution mode each cell hears all eight of its immediate neighbours. In coarse mode only cells with their flag set take part. A cell with its flag clear lets traffic pass straight through to the opposite side. The member cells therefore form four-connected meshes at reduced resolution, whatever shape the flag plane gives them.

The flag plane is written as a whole word by a single load pulse. This is how software reshapes the array while it runs, for example to pick where the coarse level sits or to step around a broken cell. Routing is combinational from the registered flags, the mode input and the broadcast bits. A bit can therefore cross any number of bypassed cells in the same cycle. Each direction is a one-way chain, so a loop cannot form.

Top module: `mesh_bypass_router`

## Requirements
- R1: After reset every flag is 0. In coarse mode, before any load, all eight receive outputs are 0 whatever the broadcast bits are.
- R2: In full mode (mode_i = 0), a cell's north, south, east and west outputs carry the broadcast bit of the cell directly adjacent in that direction, and 0 at the array edge. Cell index is row*COLS+col, row 0 is north and column 0 is west.
- R3: In full mode, the four diagonal outputs carry the broadcast bit of the diagonally adjacent cell, and 0 where no such cell exists.
- R4: In coarse mode (mode_i = 1), the orthogonal output of a member cell (flag 1) in a given direction carries the broadcast bit of the nearest member in that direction along the same row or column. Non-members in between are skipped.
- R5: In coarse mode, a member cell with no member beyond it in a direction receives 0 from that direction.
- R6: In coarse mode, a cell whose flag is 0 has all four orthogonal outputs at 0.
- R7: In coarse mode, all four diagonal outputs are 0 for every cell.
- R8: The flags take flag_plane_i at a rising clock edge where flag_load_i is 1. They keep their value at any other edge, whatever flag_plane_i holds.
- R9: A load takes effect on the routing only after its clock edge. While flag_load_i is high before that edge, the outputs still follow the old flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 selects full eight-neighbour mode, 1 selects coarse bypass mode |
| flag_load_i | input | 1 | Loads the flag plane at the next rising edge |
| flag_plane_i | input | ROWS*COLS | New membership flag per cell |
| bcast_i | input | ROWS*COLS | Broadcast bit of each cell |
| rx_n_o | output | ROWS*COLS | Bit received from the north |
| rx_s_o | output | ROWS*COLS | Bit received from the south |
| rx_e_o | output | ROWS*COLS | Bit received from the east |
| rx_w_o | output | ROWS*COLS | Bit received from the west |
| rx_ne_o | output | ROWS*COLS | Bit received from the north-east |
| rx_nw_o | output | ROWS*COLS | Bit received from the north-west |
| rx_se_o | output | ROWS*COLS | Bit received from the south-east |
| rx_sw_o | output | ROWS*COLS | Bit received from the south-west |

## Verification
The bench builds the block with its default 4x4 grid, so a flag plane or a broadcast pattern is a 16-bit word. At that size every one of the 65536 broadcast patterns can be applied in full mode. Every one of the 65536 flag planes can also be loaded in coarse mode. The sweep therefore covers every chain of bypassed cells, every isolated member and every empty row or column. The expected values come from walking the grid cell by cell in the bench.

// File: rtl/mesh_router_pkg.sv
package mesh_router_pkg;

    typedef enum logic {
        MODE_FULL   = 1'b0,
        MODE_COARSE = 1'b1
    } route_mode_e;

endpackage

// File: rtl/mesh_bypass_lane.sv
// One-way chain along a row or column. Index 0 sits at the upstream edge.
// A member launches its own bit downstream. A non-member forwards what arrives.
module mesh_bypass_lane #(
    parameter int LEN = 4
) (
    input  logic [LEN-1:0] member_i,
    input  logic [LEN-1:0] src_i,
    output logic [LEN-1:0] arrive_o
);

    always_comb begin
        logic carry;
        carry = 1'b0;
        for (int k = 0; k < LEN; k++) begin
            arrive_o[k] = carry;
            carry       = member_i[k] ? src_i[k] : carry;
        end
    end

endmodule

// File: rtl/mesh_flag_bank.sv
module mesh_flag_bank #(
    parameter int CELLS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CELLS-1:0] plane_i,
    output logic [CELLS-1:0] flag_o
);

    typedef struct packed {
        logic [CELLS-1:0] flags;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.flags = plane_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flags;

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(flag_o));

    // R8
    flag_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (flag_o == $past(plane_i)));

endmodule

// File: rtl/mesh_bypass_router.sv
module mesh_bypass_router #(
    parameter int ROWS = 4,
    parameter int COLS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i,
    input  logic                 flag_load_i,
    input  logic [ROWS*COLS-1:0] flag_plane_i,
    input  logic [ROWS*COLS-1:0] bcast_i,
    output logic [ROWS*COLS-1:0] rx_n_o,
    output logic [ROWS*COLS-1:0] rx_s_o,
    output logic [ROWS*COLS-1:0] rx_e_o,
    output logic [ROWS*COLS-1:0] rx_w_o,
    output logic [ROWS*COLS-1:0] rx_ne_o,
    output logic [ROWS*COLS-1:0] rx_nw_o,
    output logic [ROWS*COLS-1:0] rx_se_o,
    output logic [ROWS*COLS-1:0] rx_sw_o
);
    import mesh_router_pkg::*;

    localparam int CELLS = ROWS * COLS;

    route_mode_e      mode;
    logic             coarse;
    logic [CELLS-1:0] flag_q;
    logic [CELLS-1:0] member;
    logic [CELLS-1:0] raw_n, raw_s, raw_e, raw_w;
    logic [CELLS-1:0] dg_ne, dg_nw, dg_se, dg_sw;

    assign mode   = route_mode_e'(mode_i);
    assign coarse = (mode == MODE_COARSE);
    // Full mode treats every cell as a member, so each lane degenerates to one hop.
    assign member = coarse ? flag_q : '1;

    mesh_flag_bank #(.CELLS(CELLS)) i_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (flag_load_i),
        .plane_i(flag_plane_i),
        .flag_o (flag_q)
    );

    // Row lanes: eastward traffic feeds rx_w, westward traffic feeds rx_e.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [COLS-1:0] m_fw, s_fw, a_fw, m_bw, s_bw, a_bw;
        for (genvar c = 0; c < COLS; c++) begin : g_cell
            assign m_fw[c] = member[r*COLS+c];
            assign s_fw[c] = bcast_i[r*COLS+c];
            assign m_bw[c] = member[r*COLS+COLS-1-c];
            assign s_bw[c] = bcast_i[r*COLS+COLS-1-c];
            assign raw_w[r*COLS+c]        = a_fw[c];
            assign raw_e[r*COLS+COLS-1-c] = a_bw[c];
        end
        mesh_bypass_lane #(.LEN(COLS)) i_east (.member_i(m_fw), .src_i(s_fw), .arrive_o(a_fw));
        mesh_bypass_lane #(.LEN(COLS)) i_west (.member_i(m_bw), .src_i(s_bw), .arrive_o(a_bw));
    end

    // Column lanes: southward traffic feeds rx_n, northward traffic feeds rx_s.
    for (genvar c = 0; c < COLS; c++) begin : g_col
        logic [ROWS-1:0] m_fw, s_fw, a_fw, m_bw, s_bw, a_bw;
        for (genvar r = 0; r < ROWS; r++) begin : g_cell
            assign m_fw[r] = member[r*COLS+c];
            assign s_fw[r] = bcast_i[r*COLS+c];
            assign m_bw[r] = member[(ROWS-1-r)*COLS+c];
            assign s_bw[r] = bcast_i[(ROWS-1-r)*COLS+c];
            assign raw_n[r*COLS+c]          = a_fw[r];
            assign raw_s[(ROWS-1-r)*COLS+c] = a_bw[r];
        end
        mesh_bypass_lane #(.LEN(ROWS)) i_south (.member_i(m_fw), .src_i(s_fw), .arrive_o(a_fw));
        mesh_bypass_lane #(.LEN(ROWS)) i_north (.member_i(m_bw), .src_i(s_bw), .arrive_o(a_bw));
    end

    // Diagonal neighbours, used only at full resolution.
    for (genvar r = 0; r < ROWS; r++) begin : g_dr
        for (genvar c = 0; c < COLS; c++) begin : g_dc
            if (r > 0 && c < COLS-1) begin : g_ne
                assign dg_ne[r*COLS+c] = bcast_i[(r-1)*COLS+c+1];
            end else begin : g_ne0
                assign dg_ne[r*COLS+c] = 1'b0;
            end
            if (r > 0 && c > 0) begin : g_nw
                assign dg_nw[r*COLS+c] = bcast_i[(r-1)*COLS+c-1];
            end else begin : g_nw0
                assign dg_nw[r*COLS+c] = 1'b0;
            end
            if (r < ROWS-1 && c < COLS-1) begin : g_se
                assign dg_se[r*COLS+c] = bcast_i[(r+1)*COLS+c+1];
            end else begin : g_se0
                assign dg_se[r*COLS+c] = 1'b0;
            end
            if (r < ROWS-1 && c > 0) begin : g_sw
                assign dg_sw[r*COLS+c] = bcast_i[(r+1)*COLS+c-1];
            end else begin : g_sw0
                assign dg_sw[r*COLS+c] = 1'b0;
            end
        end
    end

    // A bypassed cell only relays traffic. It hears nothing itself.
    assign rx_n_o  = raw_n & member;
    assign rx_s_o  = raw_s & member;
    assign rx_e_o  = raw_e & member;
    assign rx_w_o  = raw_w & member;
    assign rx_ne_o = coarse ? '0 : dg_ne;
    assign rx_nw_o = coarse ? '0 : dg_nw;
    assign rx_se_o = coarse ? '0 : dg_se;
    assign rx_sw_o = coarse ? '0 : dg_sw;

    // R6
    nonmember_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 1'b1) |-> (((rx_n_o | rx_s_o | rx_e_o | rx_w_o) & ~flag_q) == '0));

    // R7
    diag_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 1'b1) |-> ((rx_ne_o | rx_nw_o | rx_se_o | rx_sw_o) == '0));

    // R5
    north_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((rx_n_o[COLS-1:0] | rx_nw_o[COLS-1:0] | rx_ne_o[COLS-1:0]) == '0));

    // R5
    south_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> ((rx_s_o[CELLS-1:CELLS-COLS] | rx_se_o[CELLS-1:CELLS-COLS]) == '0));

endmodule

// File: tb/test_mesh_bypass_router.sv
module test_mesh_bypass_router;

    localparam int CLK_PERIOD = 10;
    localparam int R = 4;
    localparam int C = 4;
    localparam int N = R * C;
    localparam int WATCHDOG = 190000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode = 1'b0;
    logic         load = 1'b0;
    logic [N-1:0] plane = '0;
    logic [N-1:0] bc = '0;
    logic [N-1:0] rx_n, rx_s, rx_e, rx_w, rx_ne, rx_nw, rx_se, rx_sw;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    logic [N-1:0] cur_fl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesh_bypass_router #(.ROWS(R), .COLS(C)) i_mesh_bypass_router (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .flag_load_i(load),
        .flag_plane_i(plane), .bcast_i(bc),
        .rx_n_o(rx_n), .rx_s_o(rx_s), .rx_e_o(rx_e), .rx_w_o(rx_w),
        .rx_ne_o(rx_ne), .rx_nw_o(rx_nw), .rx_se_o(rx_se), .rx_sw_o(rx_sw)
    );

    // Walk the grid from the cell in direction (dr,dc) for the expected bit.
    function automatic logic ref_bit(input int dr, input int dc, input int r, input int c,
                                     input logic co, input logic [N-1:0] fl, input logic [N-1:0] b);
        int rr;
        int cc;
        if (co && dr != 0 && dc != 0) return 1'b0;
        if (co && !fl[r*C+c]) return 1'b0;
        rr = r + dr;
        cc = c + dc;
        while (rr >= 0 && rr < R && cc >= 0 && cc < C) begin
            if (!co || fl[rr*C+cc]) return b[rr*C+cc];
            rr += dr;
            cc += dc;
        end
        return 1'b0;
    endfunction

    task automatic check_all(input string tag_o, input string tag_d, input logic [N-1:0] fl);
        for (int d = 0; d < 8; d++) begin
            int dr;
            int dc;
            logic [N-1:0] got;
            logic [N-1:0] exp;
            case (d)
                0: begin dr = -1; dc =  0; got = rx_n;  end
                1: begin dr =  1; dc =  0; got = rx_s;  end
                2: begin dr =  0; dc =  1; got = rx_e;  end
                3: begin dr =  0; dc = -1; got = rx_w;  end
                4: begin dr = -1; dc =  1; got = rx_ne; end
                5: begin dr = -1; dc = -1; got = rx_nw; end
                6: begin dr =  1; dc =  1; got = rx_se; end
                default: begin dr = 1; dc = -1; got = rx_sw; end
            endcase
            for (int r = 0; r < R; r++)
                for (int c = 0; c < C; c++)
                    exp[r*C+c] = ref_bit(dr, dc, r, c, mode, fl, bc);
            compared++;
            if (got !== exp) begin
                mismatched++;
                $display("FAIL %s dir%0d mode=%0b flags=%h bcast=%h: got %h expected %h",
                         (d < 4) ? tag_o : tag_d, d, mode, fl, bc, got, exp);
            end
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset state, coarse mode with every broadcast bit high
        mode = 1'b1;
        bc = '1;
        repeat (2) @(negedge clk);
        #1 check_all("R1", "R1", '0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check_all("R1", "R1", '0);

        // R2 R3: full mode, every broadcast pattern
        mode = 1'b0;
        for (int p = 0; p < (1 << N); p++) begin
            bc = N'(p);
            #1 check_all("R2", "R3", cur_fl);
        end

        // R4 R5 R6 R7 R9: coarse mode, every flag plane
        mode = 1'b1;
        @(negedge clk);
        for (int p = 0; p < (1 << N); p++) begin
            @(negedge clk);
            plane = N'(p);
            load = 1'b1;
            bc = N'(p) ^ 16'h5A3C;
            #1 check_all("R9", "R9", cur_fl);
            @(posedge clk);
            cur_fl = N'(p);
            #1 check_all("R4/R5/R6", "R7", cur_fl);
            bc = ~N'(p);
            #1 check_all("R4/R5/R6", "R7", cur_fl);
            bc = N'(p * 40503);
            #1 check_all("R4/R5/R6", "R7", cur_fl);
            if ((p % 4096) == 7) begin
                // R8: plane changes without a load leave the routing alone
                @(negedge clk);
                load = 1'b0;
                plane = ~N'(p);
                repeat (2) @(posedge clk);
                #1 check_all("R8", "R8", cur_fl);
                mode = 1'b0;
                repeat (1) @(posedge clk);
                mode = 1'b1;
                #1 check_all("R8", "R8", cur_fl);
            end
        end

        @(negedge clk);
        load = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule